// File: doc/BRIEF.md
# Engine Lifecycle State Controller

This controller holds the lifecycle state of a single engine resource inside a processor core. Each cycle it can take one transition request, identified by a 3-bit code, and one command, identified by a 2-bit class and an index. It moves between six states and decides whether the request or command is allowed in the state it is in. Anything that is not allowed produces a one-cycle fault pulse and changes nothing.

Initialization stands in for a preprocessing step of fixed length, which a counter models. While that counter runs the block reports busy. Saving exposes a fixed number of state words that can be read by index. Restoring accepts those words back only as a gap-free ascending sequence. After the last word arrives, the engine becomes ready again.

The asynchronous active-low reset is released through a two-stage synchronizer, so the block leaves reset two rising edges after `rst_n` goes high. Every output is registered. The effect of an input therefore shows on the outputs in the cycle after the edge that samples it.

Top module: `eng_life_ctrl`

## Requirements
- R1: The state output is 3 bits: uninitialized=0, ready=1, running=2, paused=3, saving=4, resuming=5. Reset gives state 0 with fault and busy low.
- R2: Request code 0 (initialize), when the state is uninitialized and the block is not busy, raises busy for PREP_CYCLES cycles beginning the cycle after the request. The state stays uninitialized during that time and becomes ready in the cycle busy drops.
- R3: Code 1 (start) moves ready to running. Code 3 (unpause) moves paused to running.
- R4: Code 2 (pause) moves running to paused. In every other state it changes nothing and does not fault.
- R5: Code 4 (enter save) moves ready or paused to saving. Code 5 (enter resume) is allowed only from uninitialized, moves to resuming and sets the expected restore index to 0.
- R6: Code 6 (reset) returns any state to uninitialized when the block is not busy.
- R7: A request code that is not allowed in the current state, and code 7 in any state, raises fault for one cycle in the cycle after the request and leaves the state unchanged.
- R8: Any request that arrives while busy is high raises fault and has no other effect.
- R9: Command class 0 (count query) is allowed only in saving. Class 1 (word read) is allowed only in saving with an index below SAVE_WORDS. Class 3 is never allowed. Each disallowed command raises fault.
- R10: Command class 2 (restore write) is allowed only in resuming, and only with an index equal to the expected index. An accepted write advances the expected index by one. Any other write faults and leaves the state and the expected index unchanged.
- R11: An accepted restore write of index SAVE_WORDS-1 ends the sequence and moves the state to ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transition request present |
| req_code | input | 3 | Transition code |
| cmd_valid | input | 1 | Command present |
| cmd_kind | input | 2 | Command class |
| cmd_idx | input | IDX_W | Word index for a read or restore write |
| state_o | output | 3 | Current lifecycle state |
| fault_o | output | 1 | One-cycle pulse for a disallowed request or command |
| busy_o | output | 1 | Initialization preprocessing in progress |

## Verification
The assertions assume that a request and a command never arrive in the same cycle. They also assume that no command index reaches 2^IDX_W, so an index cannot wrap onto a legal value. The stimulus keeps to both rules by issuing one input per cycle. It reaches out-of-range indexes with values up to 7 while SAVE_WORDS is 4. The bench's reference model runs under the same rules, so write ordering, busy-time requests and ignored pauses are each checked against its own tracking.

// File: rtl/eng_life_pkg.sv
package eng_life_pkg;

  typedef enum logic [2:0] {
    ST_UNINIT = 3'd0,
    ST_READY  = 3'd1,
    ST_RUN    = 3'd2,
    ST_PAUSED = 3'd3,
    ST_SAVING = 3'd4,
    ST_RESUME = 3'd5
  } eng_state_e;

  typedef enum logic [2:0] {
    RQ_INIT    = 3'd0,
    RQ_START   = 3'd1,
    RQ_PAUSE   = 3'd2,
    RQ_UNPAUSE = 3'd3,
    RQ_SAVE    = 3'd4,
    RQ_RESUME  = 3'd5,
    RQ_RESET   = 3'd6,
    RQ_BAD     = 3'd7
  } eng_req_e;

  typedef enum logic [1:0] {
    CK_COUNT = 2'd0,
    CK_READ  = 2'd1,
    CK_WRITE = 2'd2,
    CK_BAD   = 2'd3
  } eng_cmd_e;

endpackage

// File: rtl/eng_prep_timer.sv
module eng_prep_timer #(
  parameter int PREP_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (PREP_CYCLES > 1) ? $clog2(PREP_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(PREP_CYCLES - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start_i && !busy_q) begin
      busy_d = 1'b1;
      cnt_d  = LOAD;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  // R2: the controller only launches preprocessing while the timer is idle
  p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_q);

endmodule

// File: rtl/eng_restore_seq.sv
module eng_restore_seq #(
  parameter int SAVE_WORDS = 4,
  parameter int IDX_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] exp_idx_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SAVE_WORDS - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             en;

  assign en = clear_i || adv_i;

  always_comb begin
    idx_d = idx_q;
    if (clear_i)    idx_d = '0;
    else if (adv_i) idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  idx_q <= '0;
    else if (en) idx_q <= idx_d;
  end

  assign exp_idx_o = idx_q;
  assign last_o    = (idx_q == LAST_IDX);

  // R10: the expected index never leaves the legal word range
  p_idx_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST_IDX);

endmodule

// File: rtl/eng_life_ctrl.sv
module eng_life_ctrl
  import eng_life_pkg::*;
#(
  parameter int PREP_CYCLES = 8,
  parameter int SAVE_WORDS  = 4,
  parameter int IDX_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_code,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_kind,
  input  logic [IDX_W-1:0] cmd_idx,
  output logic [2:0]       state_o,
  output logic             fault_o,
  output logic             busy_o
);
  localparam logic [IDX_W-1:0] NWORDS = IDX_W'(SAVE_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SAVE_WORDS - 1);

  // reset: asynchronous assert, synchronous release
  logic rs_meta, rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rst_n_i <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rst_n_i <= rs_meta;
    end
  end

  eng_state_e       st_q, st_d;
  logic             flt_q, flt_d;
  logic             prep_go, prep_busy, prep_done;
  logic             seq_clr, seq_adv, seq_last;
  logic [IDX_W-1:0] exp_idx;

  eng_prep_timer #(.PREP_CYCLES(PREP_CYCLES)) u_prep (
    .clk(clk), .rst_n(rst_n_i), .start_i(prep_go),
    .busy_o(prep_busy), .done_o(prep_done)
  );

  eng_restore_seq #(.SAVE_WORDS(SAVE_WORDS), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n_i), .clear_i(seq_clr), .adv_i(seq_adv),
    .exp_idx_o(exp_idx), .last_o(seq_last)
  );

  always_comb begin
    st_d    = st_q;
    flt_d   = 1'b0;
    prep_go = 1'b0;
    seq_clr = 1'b0;
    seq_adv = 1'b0;
    if (prep_done) st_d = ST_READY;
    if (req_valid) begin
      if (prep_busy) begin
        flt_d = 1'b1;
      end else begin
        unique case (eng_req_e'(req_code))
          RQ_INIT:    if (st_q == ST_UNINIT) prep_go = 1'b1;
                      else flt_d = 1'b1;
          RQ_START:   if (st_q == ST_READY) st_d = ST_RUN;
                      else flt_d = 1'b1;
          RQ_PAUSE:   if (st_q == ST_RUN) st_d = ST_PAUSED;
          RQ_UNPAUSE: if (st_q == ST_PAUSED) st_d = ST_RUN;
                      else flt_d = 1'b1;
          RQ_SAVE:    if (st_q == ST_READY || st_q == ST_PAUSED) st_d = ST_SAVING;
                      else flt_d = 1'b1;
          RQ_RESUME:  if (st_q == ST_UNINIT) begin
                        st_d    = ST_RESUME;
                        seq_clr = 1'b1;
                      end else flt_d = 1'b1;
          RQ_RESET:   st_d = ST_UNINIT;
          default:    flt_d = 1'b1;
        endcase
      end
    end
    if (cmd_valid) begin
      unique case (eng_cmd_e'(cmd_kind))
        CK_COUNT: if (st_q != ST_SAVING) flt_d = 1'b1;
        CK_READ:  if (st_q != ST_SAVING || cmd_idx >= NWORDS) flt_d = 1'b1;
        CK_WRITE: if (st_q == ST_RESUME && cmd_idx == exp_idx) begin
                    if (seq_last) st_d = ST_READY;
                    else          seq_adv = 1'b1;
                  end else flt_d = 1'b1;
        default:  flt_d = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q  <= ST_UNINIT;
      flt_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      flt_q <= flt_d;
    end
  end

  assign state_o = st_q;
  assign fault_o = flt_q;
  assign busy_o  = prep_busy;

  // R1: only the six defined encodings appear
  p_state_enc_r1: assert property (@(posedge clk) disable iff (!rst_n_i)
    st_q <= ST_RESUME);

  // R2: preprocessing runs only while uninitialized and ends in ready
  p_prep_state_r2: assert property (@(posedge clk) disable iff (!rst_n_i)
    prep_busy |-> st_q == ST_UNINIT);
  p_prep_end_r2: assert property (@(posedge clk) disable iff (!rst_n_i)
    $fell(prep_busy) |-> st_q == ST_READY);

  // R4: pause outside running is silent
  p_pause_noop_r4: assert property (@(posedge clk) disable iff (!rst_n_i)
    (req_valid && !cmd_valid && !prep_busy && req_code == 3'd2 && st_q != ST_RUN)
      |=> $stable(st_q) && !flt_q);

  // R5: resuming is entered only from uninitialized
  p_resume_src_r5: assert property (@(posedge clk) disable iff (!rst_n_i)
    (st_q == ST_RESUME && $past(st_q) != ST_RESUME) |-> $past(st_q) == ST_UNINIT);

  // R8: a request during preprocessing faults
  p_busy_fault_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
    (req_valid && prep_busy) |=> flt_q);

  // R11: leaving resuming for ready needs a write of the final index
  p_restore_done_r11: assert property (@(posedge clk) disable iff (!rst_n_i)
    ($past(st_q) == ST_RESUME && st_q == ST_READY)
      |-> ($past(cmd_valid) && $past(cmd_idx) == LAST_IDX));

endmodule

// File: tb/eng_life_ctrl_tb_top.sv
module eng_life_ctrl_tb_top;
  localparam int PREP = 8;
  localparam int W    = 4;
  localparam int IW   = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [2:0]    req_code = '0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_kind = '0;
  logic [IW-1:0] cmd_idx = '0;
  logic [2:0]    state_o;
  logic          fault_o, busy_o;

  int total = 0;
  int bad   = 0;
  int m_state = 0, m_busy = 0, m_cnt = 0, m_exp = 0, m_fault = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  eng_life_ctrl #(.PREP_CYCLES(PREP), .SAVE_WORDS(W), .IDX_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_idx(cmd_idx),
    .state_o(state_o), .fault_o(fault_o), .busy_o(busy_o)
  );

  task automatic chk(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("state", int'(state_o), m_state);
    chk("fault", int'(fault_o), m_fault);
    chk("busy",  int'(busy_o),  m_busy);
  endtask

  // behavioural reference of one clock edge
  task automatic model(input bit rv, input int rc, input bit cv, input int ck, input int ci);
    int ns;
    int f;
    ns = m_state;
    f  = 0;
    if (m_busy != 0) begin
      if (rv) f = 1;
      if (m_cnt == 0) begin m_busy = 0; ns = 1; end
      else m_cnt--;
    end else if (rv) begin
      case (rc)
        0: if (m_state == 0) begin m_busy = 1; m_cnt = PREP - 1; end else f = 1;
        1: if (m_state == 1) ns = 2; else f = 1;
        2: if (m_state == 2) ns = 3;
        3: if (m_state == 3) ns = 2; else f = 1;
        4: if (m_state == 1 || m_state == 3) ns = 4; else f = 1;
        5: if (m_state == 0) begin ns = 5; m_exp = 0; end else f = 1;
        6: ns = 0;
        default: f = 1;
      endcase
    end
    if (cv) begin
      case (ck)
        0: if (m_state != 4) f = 1;
        1: if (m_state != 4 || ci >= W) f = 1;
        2: if (m_state == 5 && ci == m_exp) begin
             if (m_exp == W - 1) ns = 1; else m_exp++;
           end else f = 1;
        default: f = 1;
      endcase
    end
    m_state = ns;
    m_fault = f;
  endtask

  task automatic step(input bit rv, input int rc, input bit cv, input int ck, input int ci);
    req_valid = rv; req_code = 3'(rc);
    cmd_valid = cv; cmd_kind = 2'(ck); cmd_idx = IW'(ci);
    @(posedge clk);
    model(rv, rc, cv, ck, ci);
    @(negedge clk);
    req_valid = 1'b0; cmd_valid = 1'b0;
    compare_all();
  endtask

  task automatic req(input int rc);  step(1'b1, rc, 1'b0, 0, 0); endtask
  task automatic cmd(input int ck, input int ci); step(1'b0, 0, 1'b1, ck, ci); endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    tag = "R1"; compare_all();

    tag = "R7";  req(1);  req(3);  req(7);
    tag = "R4";  req(2);
    tag = "R9";  cmd(0, 0); cmd(1, 0); cmd(3, 0);
    tag = "R10"; cmd(2, 0);

    tag = "R2";  req(0);
    tag = "R8";  req(1); req(6);
    tag = "R2";  idle(PREP);
    tag = "R7";  req(0); req(5);
    tag = "R4";  req(2);
    tag = "R3";  req(1);
    tag = "R4";  req(2); req(2);
    tag = "R3";  req(3);
    tag = "R7";  req(4);
    tag = "R4";  req(2);
    tag = "R5";  req(4);

    tag = "R9";  cmd(0, 0);
    for (int i = 0; i < W; i++) cmd(1, i);
    cmd(1, W); cmd(1, 7); cmd(3, 2);
    tag = "R10"; cmd(2, 0);
    tag = "R7";  req(1); req(7);
    tag = "R6";  req(6);

    tag = "R5";  req(5);
    tag = "R10"; cmd(2, 1); cmd(2, 0); cmd(2, 0); cmd(2, 2); cmd(2, 7);
    cmd(2, 1); cmd(2, 2);
    tag = "R9";  cmd(0, 0);
    tag = "R11"; cmd(2, 3);
    tag = "R3";  req(1);
    tag = "R6";  req(6);
    tag = "R5";  req(5); req(5);
    tag = "R6";  req(6);
    tag = "R5";  req(5);
    tag = "R11";
    for (int i = 0; i < W; i++) cmd(2, i);
    tag = "R10"; cmd(2, 0);
    tag = "R5";  req(4);
    tag = "R6";  req(6);
    tag = "R2";  req(0); idle(PREP + 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule